// File: doc/BRIEF.md
# Pin-Selected Spread-Spectrum Sweep Controller

This block sits beside a fractional frequency synthesizer and turns a small set of strap pins into an operating configuration. Three select pins choose the CPU speed class and one of four behaviours: tri-stated outputs, a reference-divided test mode, center spread, or one of two down-spread depths. A separate active-low enable gates the modulation.

While modulation runs, the block produces a signed frequency-offset word in units of 0.01 %. The word traces a symmetric triangle, one unit per step. The step interval is derived from a period parameter and the span of the selected range. Pin and enable changes are only adopted when the sweep sits at zero offset at the end of a period, so the synthesizer never sees a jump in frequency.

The controller is a four-state machine:
- **IDLE**: no sweep. The pins are adopted every cycle. It moves to ANCHOR when a spreading configuration is enabled.
- **ANCHOR**: parked at zero. On the next step tick it re-reads the pins. It then launches into RISE (center), FALL (down), or drops back to IDLE (no spread).
- **RISE**: offset climbs. It goes to FALL at the upper limit, and to ANCHOR when it arrives back at zero.
- **FALL**: offset drops. It goes to RISE at the lower limit.

Top module: `ssc_mode_ctrl`

## Requirements
- R1: During and right after reset, freq_ofs is 0, spread_on is 0, mode_code is 3'b000, outs_hiz is 1, test_mode is 0 and cpu_bus_ratio is 0.
- R2: mode_code reports the adopted select triple as {speed_sel, band_sel[1], band_sel[0]}. cpu_bus_ratio is 2 when speed_sel is 0 and band_sel is nonzero, 3 when speed_sel is 1, and 0 for code 3'b000.
- R3: Code 3'b000 sets outs_hiz to 1 and keeps freq_ofs at 0 whatever the level of spread_en_n.
- R4: Code 3'b100 sets test_mode to 1 and cpu_bus_ratio to 3, and keeps freq_ofs at 0 whatever the level of spread_en_n.
- R5: The offset only moves while spread_en_n is 0 and band_sel is nonzero. Otherwise spread_on is 0 and freq_ofs stays 0.
- R6: With band_sel = 2'b01, the sweep goes 0 → +CENTER_LIM → −CENTER_LIM → 0. Each step changes freq_ofs by exactly one unit (default limit 90, i.e. ±0.9 %).
- R7: With band_sel = 2'b10, the sweep goes 0 → −WIDE_LIM → 0 (default 100, −1 %). With band_sel = 2'b11, it goes 0 → −NARROW_LIM → 0 (default 50, −0.5 %). Down sweeps never go above 0.
- R8: The step interval is floor(SWEEP_CYCLES/(4·CENTER_LIM)) cycles for center, floor(SWEEP_CYCLES/(2·WIDE_LIM)) for wide down and floor(SWEEP_CYCLES/(2·NARROW_LIM)) for narrow down, each at least 1. The first step comes that many cycles after the edge that adopts a spreading configuration out of IDLE.
- R9: Pin or enable changes made while the sweep is away from zero take no effect until the period ends at zero. One further step interval of the old setting then passes before the new setting acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_sel | input | 1 | CPU speed class select (0: 66.6 MHz class, 1: 100 MHz class) |
| band_sel | input | 2 | Behaviour select: 00 off/test, 01 center, 10 wide down, 11 narrow down |
| spread_en_n | input | 1 | Active-low modulation enable |
| mode_code | output | 3 | Adopted select triple |
| spread_on | output | 1 | Adopted configuration is sweeping |
| cpu_bus_ratio | output | 2 | Nominal CPU-to-bus clock divide ratio |
| outs_hiz | output | 1 | Clock outputs to high impedance |
| test_mode | output | 1 | Reference-divided test mode |
| freq_ofs | output | OFS_W | Signed frequency offset, units of 0.01 % |

## Verification
In IDLE, the mode outputs change one edge after the pins. The first offset step comes one step interval after that adopting edge, and every later step comes exactly one interval after the previous one. A step at the end of a period is followed by one interval of the old setting before the new one takes effect. The scoreboard queues every expected offset value together with its due interval, and the monitor compares both against the edge count at which freq_ofs actually moved, sampling on falling edges. Checks on deferred pin changes are taken a few cycles after the change, while the sweep is known to be away from zero. Checks that a new configuration has taken effect wait until the queue has drained plus at least two step intervals.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int OFS_W  = 8;
    localparam int TICK_W = 16;

    typedef struct packed {
        logic [2:0]        code;
        logic              spread_on;
        logic              center;
        logic [OFS_W-1:0]  lim;
        logic [TICK_W-1:0] tick_len;
        logic [1:0]        ratio;
        logic              hiz;
        logic              test;
    } ssc_cfg_t;

    localparam ssc_cfg_t CFG_RESET = '{
        code:      3'b000,
        spread_on: 1'b0,
        center:    1'b0,
        lim:       '0,
        tick_len:  TICK_W'(1),
        ratio:     2'd0,
        hiz:       1'b1,
        test:      1'b0
    };
endpackage

// File: rtl/ssc_pin_decode.sv
module ssc_pin_decode
    import ssc_pkg::*;
#(
    parameter int SWEEP_CYCLES = 4166,
    parameter int CENTER_LIM   = 90,
    parameter int WIDE_LIM     = 100,
    parameter int NARROW_LIM   = 50
) (
    input  logic       speed_sel,
    input  logic [1:0] band_sel,
    input  logic       spread_en_n,
    output ssc_cfg_t   cfg
);
    localparam int RAW_C = SWEEP_CYCLES / (4 * CENTER_LIM);
    localparam int RAW_W = SWEEP_CYCLES / (2 * WIDE_LIM);
    localparam int RAW_N = SWEEP_CYCLES / (2 * NARROW_LIM);
    localparam int TICK_C = (RAW_C < 1) ? 1 : RAW_C;
    localparam int TICK_WD = (RAW_W < 1) ? 1 : RAW_W;
    localparam int TICK_N = (RAW_N < 1) ? 1 : RAW_N;

    always_comb begin
        cfg          = CFG_RESET;
        cfg.hiz      = 1'b0;
        cfg.code     = {speed_sel, band_sel};
        cfg.ratio    = speed_sel ? 2'd3 : 2'd2;
        unique case (band_sel)
            2'b00: begin
                if (speed_sel) begin
                    cfg.test = 1'b1;
                end else begin
                    cfg.hiz   = 1'b1;
                    cfg.ratio = 2'd0;
                end
            end
            2'b01: begin
                cfg.center    = 1'b1;
                cfg.lim       = OFS_W'(CENTER_LIM);
                cfg.tick_len  = TICK_W'(TICK_C);
                cfg.spread_on = !spread_en_n;
            end
            2'b10: begin
                cfg.lim       = OFS_W'(WIDE_LIM);
                cfg.tick_len  = TICK_W'(TICK_WD);
                cfg.spread_on = !spread_en_n;
            end
            2'b11: begin
                cfg.lim       = OFS_W'(NARROW_LIM);
                cfg.tick_len  = TICK_W'(TICK_N);
                cfg.spread_on = !spread_en_n;
            end
            default: cfg = CFG_RESET;
        endcase
    end
endmodule

// File: rtl/ssc_step_timer.sv
module ssc_step_timer
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [TICK_W-1:0] len,
    output logic              tick
);
    logic [TICK_W-1:0] cnt_q;

    assign tick = !clear && (cnt_q == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q < len)); // R8
endmodule

// File: rtl/ssc_sweep_fsm.sv
module ssc_sweep_fsm
    import ssc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  ssc_cfg_t                live_cfg,
    input  logic                    tick,
    output ssc_cfg_t                cfg_q,
    output logic signed [OFS_W-1:0] ofs_q,
    output logic                    timer_clear
);
    typedef enum logic [1:0] {S_IDLE, S_ANCHOR, S_RISE, S_FALL} sweep_state_t;

    localparam logic signed [OFS_W-1:0] ZERO      = '0;
    localparam logic signed [OFS_W-1:0] ONE       = OFS_W'(1);
    localparam logic signed [OFS_W-1:0] MINUS_ONE = '1;

    sweep_state_t            state_q, state_d;
    ssc_cfg_t                cfg_d;
    logic signed [OFS_W-1:0] ofs_d;
    logic signed [OFS_W-1:0] ofs_up;
    logic signed [OFS_W-1:0] ofs_dn;
    logic signed [OFS_W-1:0] lim_s;

    assign lim_s  = $signed(cfg_q.lim);
    assign ofs_up = ofs_q + ONE;
    assign ofs_dn = ofs_q - ONE;

    // next state and next outputs
    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        ofs_d   = ofs_q;
        unique case (state_q)
            S_IDLE: begin
                cfg_d = live_cfg;
                if (live_cfg.spread_on) begin
                    state_d = S_ANCHOR;
                end
            end
            S_ANCHOR: begin
                if (tick) begin
                    cfg_d = live_cfg;
                    if (!live_cfg.spread_on) begin
                        state_d = S_IDLE;
                    end else if (live_cfg.center) begin
                        state_d = S_RISE;
                        ofs_d   = ONE;
                    end else begin
                        state_d = S_FALL;
                        ofs_d   = MINUS_ONE;
                    end
                end
            end
            S_RISE: begin
                if (tick) begin
                    ofs_d = ofs_up;
                    if (ofs_up == ZERO) begin
                        state_d = S_ANCHOR;
                    end else if (ofs_up == lim_s) begin
                        state_d = S_FALL;
                    end
                end
            end
            S_FALL: begin
                if (tick) begin
                    ofs_d = ofs_dn;
                    if (ofs_dn == -lim_s) begin
                        state_d = S_RISE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cfg_q   <= CFG_RESET;
            ofs_q   <= ZERO;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
            ofs_q   <= ofs_d;
        end
    end

    assign timer_clear = (state_q == S_IDLE);

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_q == $past(ofs_q)) || (ofs_q == $past(ofs_q) + ONE)
        || (ofs_q == $past(ofs_q) - ONE)); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.spread_on |-> (ofs_q == ZERO)); // R5
    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.hiz |-> (ofs_q == ZERO)); // R3
    AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.test |-> (ofs_q == ZERO)); // R4
    AST_CENTER_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.center |-> (ofs_q <= lim_s && ofs_q >= -lim_s)); // R6
    AST_DOWN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.center |-> (ofs_q <= ZERO && ofs_q >= -lim_s)); // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ofs_q) != ZERO) |-> $stable(cfg_q)); // R9
endmodule

// File: rtl/ssc_mode_ctrl.sv
module ssc_mode_ctrl
    import ssc_pkg::*;
#(
    parameter int SWEEP_CYCLES = 4166,
    parameter int CENTER_LIM   = 90,
    parameter int WIDE_LIM     = 100,
    parameter int NARROW_LIM   = 50
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             speed_sel,
    input  logic [1:0]                       band_sel,
    input  logic                             spread_en_n,
    output logic [2:0]                       mode_code,
    output logic                             spread_on,
    output logic [1:0]                       cpu_bus_ratio,
    output logic                             outs_hiz,
    output logic                             test_mode,
    output logic signed [ssc_pkg::OFS_W-1:0] freq_ofs
);
    ssc_cfg_t live_cfg;
    ssc_cfg_t cfg_q;
    logic     tick;
    logic     timer_clear;

    ssc_pin_decode #(
        .SWEEP_CYCLES(SWEEP_CYCLES),
        .CENTER_LIM  (CENTER_LIM),
        .WIDE_LIM    (WIDE_LIM),
        .NARROW_LIM  (NARROW_LIM)
    ) u_decode (
        .speed_sel  (speed_sel),
        .band_sel   (band_sel),
        .spread_en_n(spread_en_n),
        .cfg        (live_cfg)
    );

    ssc_step_timer u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(timer_clear),
        .len  (cfg_q.tick_len),
        .tick (tick)
    );

    ssc_sweep_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_cfg   (live_cfg),
        .tick       (tick),
        .cfg_q      (cfg_q),
        .ofs_q      (freq_ofs),
        .timer_clear(timer_clear)
    );

    assign mode_code     = cfg_q.code;
    assign spread_on     = cfg_q.spread_on;
    assign cpu_bus_ratio = cfg_q.ratio;
    assign outs_hiz      = cfg_q.hiz;
    assign test_mode     = cfg_q.test;
endmodule

// File: tb/tb_ssc_mode_ctrl.sv
module tb_ssc_mode_ctrl;
    localparam int SWEEP = 720;
    localparam int T_C = SWEEP / 360;
    localparam int T_W = SWEEP / 200;
    localparam int T_N = SWEEP / 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_sel = 1'b0;
    logic [1:0] band_sel = 2'b00;
    logic spread_en_n = 1'b1;
    logic [2:0] mode_code;
    logic spread_on;
    logic [1:0] cpu_bus_ratio;
    logic outs_hiz;
    logic test_mode;
    logic signed [7:0] freq_ofs;

    always #4 clk = ~clk;

    ssc_mode_ctrl #(.SWEEP_CYCLES(SWEEP)) dut (
        .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .band_sel(band_sel),
        .spread_en_n(spread_en_n), .mode_code(mode_code), .spread_on(spread_on),
        .cpu_bus_ratio(cpu_bus_ratio), .outs_hiz(outs_hiz), .test_mode(test_mode),
        .freq_ofs(freq_ofs)
    );

    typedef struct {
        int    val;
        int    gap;
        string req;
    } exp_t;

    exp_t q[$];
    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_cyc = 0;
    int last_ofs = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int v, input int g, input string req);
        exp_t e;
        e.val = v;
        e.gap = g;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic push_center(input int first_gap);
        int g = first_gap;
        for (int v = 1; v <= 90; v++) begin push(v, g, "R6"); g = T_C; end
        for (int v = 89; v >= -90; v--) push(v, T_C, "R6");
        for (int v = -89; v <= 0; v++) push(v, T_C, "R6");
    endtask

    task automatic push_down(input int lim, input int t, input int first_gap);
        int g = first_gap;
        for (int v = -1; v >= -lim; v--) begin push(v, g, "R7"); g = t; end
        for (int v = -lim + 1; v <= 0; v++) push(v, t, "R7");
    endtask

    task automatic wait_q(input int n);
        while (q.size() > n) @(negedge clk);
    endtask

    // monitor: compares each offset change against the queue
    always @(negedge clk) begin
        if (rst_n && int'(freq_ofs) != last_ofs) begin
            if (q.size() == 0) begin
                check("R5", "unexpected offset change", int'(freq_ofs), last_ofs);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.req, "offset value", int'(freq_ofs), e.val);
                if (e.gap != 0) check("R8", "step interval", cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
            last_ofs = int'(freq_ofs);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", q.size(), 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", "freq_ofs", int'(freq_ofs), 0);
        check("R1", "spread_on", spread_on, 0);
        check("R1", "mode_code", mode_code, 0);
        check("R1", "outs_hiz", outs_hiz, 1);
        check("R1", "test_mode", test_mode, 0);
        check("R1", "ratio", cpu_bus_ratio, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "freq_ofs after release", int'(freq_ofs), 0);

        // R3 tri-state code ignores enable
        spread_en_n = 1'b0;
        repeat (30) @(negedge clk);
        check("R3", "outs_hiz", outs_hiz, 1);
        check("R3", "freq_ofs", int'(freq_ofs), 0);
        check("R3", "ratio", cpu_bus_ratio, 0);

        // R4 test code ignores enable
        speed_sel = 1'b1;
        repeat (30) @(negedge clk);
        check("R4", "test_mode", test_mode, 1);
        check("R4", "outs_hiz", outs_hiz, 0);
        check("R4", "ratio", cpu_bus_ratio, 3);
        check("R4", "freq_ofs", int'(freq_ofs), 0);

        // R5 center code with enable high
        speed_sel = 1'b0;
        band_sel = 2'b01;
        spread_en_n = 1'b1;
        repeat (30) @(negedge clk);
        check("R5", "spread_on", spread_on, 0);
        check("R5", "freq_ofs", int'(freq_ofs), 0);
        check("R2", "mode_code", mode_code, 1);
        check("R2", "ratio", cpu_bus_ratio, 2);

        // R6 center sweep from IDLE
        spread_en_n = 1'b0;
        last_cyc = cyc + 1;
        push_center(T_C);
        repeat (3) @(negedge clk);
        check("R2", "spread_on", spread_on, 1);
        check("R2", "mode_code", mode_code, 1);
        wait_q(200);
        // R9 mid-sweep change to narrow down is held back
        band_sel = 2'b11;
        push_down(50, T_N, T_C);
        repeat (3) @(negedge clk);
        check("R9", "mode_code held", mode_code, 1);
        wait_q(30);
        spread_en_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "spread_on held", spread_on, 1);
        check("R9", "mode_code narrow", mode_code, 3);
        wait_q(0);
        repeat (2 * T_N + 5) @(negedge clk);
        check("R5", "spread_on off", spread_on, 0);
        check("R5", "freq_ofs", int'(freq_ofs), 0);

        // R7 wide down sweep, 100 MHz class
        speed_sel = 1'b1;
        band_sel = 2'b10;
        spread_en_n = 1'b0;
        last_cyc = cyc + 1;
        push_down(100, T_W, T_W);
        repeat (3) @(negedge clk);
        check("R2", "mode_code wide", mode_code, 6);
        check("R2", "ratio", cpu_bus_ratio, 3);
        wait_q(100);
        speed_sel = 1'b0;
        band_sel = 2'b00;
        repeat (2) @(negedge clk);
        check("R9", "outs_hiz held", outs_hiz, 0);
        wait_q(0);
        repeat (2 * T_W + 5) @(negedge clk);
        check("R3", "outs_hiz", outs_hiz, 1);
        check("R3", "freq_ofs", int'(freq_ofs), 0);
        check("R3", "spread_on", spread_on, 0);
        repeat (20) @(negedge clk);
        check("R7", "queue drained", q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule